// File: doc/BRIEF.md
# Single-Move Predictive Speed Controller

This block computes one actuator command update per sampling instant for a motor whose speed follows a first-order discrete model. On a start strobe it captures a measured speed and a speed setpoint. It advances its internal model by one step and forms a disturbance estimate from the gap between measurement and model. It then predicts the free speed trajectory over a ten-sample horizon, assuming the command stays at its last value.

The optimal move comes from a single-move predictive law with no move penalty. It is a weighted sum of the ten setpoint-minus-prediction errors, using precomputed gains. No division happens at run time. The move is added to the held command, the result is clamped to the actuator range, and a one-cycle done flag is raised.

All arithmetic is signed fixed point. Values use a 32-bit word with 18 fractional bits. A single multiplier is shared across every step of the computation, so one update takes a fixed number of clock cycles.

Top module: `spd_pred_ctrl`

## Requirements
- R1: A synchronous reset sets the command output to 0, sets done to 0, and clears the model state and the held command to 0. The next update therefore starts from a zero model.
- R2: Every value is two's complement with 18 fractional bits (1.0 = 262144). Each product is rounded as (p + 131072) shifted right arithmetically by 18.
- R3: The model step is x = rnd(246415·x_prev) + rnd(403702·u_prev). For k = 1..10, the free prediction iterates xf_k = rnd(246415·xf_{k-1}) + rnd(403702·u_prev), starting from xf_0 = x.
- R4: The disturbance n = y − x is held across the horizon. The k-th free prediction is xf_k + n.
- R5: The move is Δu = Σ rnd(h_k·(r − xf_k − n)) for k = 1..10, summed in order of k. The gains h_1..h_10 are 656, 1273, 1853, 2398, 2911, 3393, 3845, 4271, 4671, 5047.
- R6: The new command is u_prev + Δu, clamped to the range 0 to 26214400 (100.0).
- R7: done is high for exactly one cycle, 23 clock edges after the edge that samples start. The command output changes only in the cycle where done is high.
- R8: Start pulses, speed and setpoint changes while an update is in progress are ignored. Inputs are captured only at the accepted start.
- R9: After each update, the model value x and the new command become x_prev and u_prev for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request for a new update |
| y_meas | input | 32 | Measured speed, signed, 18 fractional bits |
| r_set | input | 32 | Speed setpoint, signed, 18 fractional bits |
| u_out | output | 32 | Actuator command, 18 fractional bits, 0 to 100.0 |
| done | output | 1 | One-cycle flag marking a new command |

## Verification
The first update starts from the zero reset state, where the free prediction is flat and the move reduces to the gain sum times the setpoint. This isolates the gain table and the product rounding. A chain of updates follows in three forms: the measurement equals the model, the measurement is offset from the model, and the setpoint steps. This separates the model recursion and the carried state from the disturbance term. Very high and very low setpoints tell the two clamp limits apart. Extra start pulses with changed inputs during a busy update, and a reset in the middle of an update, show that capture happens once and that the state really clears.

// File: rtl/spd_pred_ctrl.sv
module spd_pred_ctrl #(
  parameter int W = 32,
  parameter int FRAC = 18,
  parameter int HOR = 10,
  parameter logic signed [W-1:0] A_COEF = 246415,
  parameter logic signed [W-1:0] B_COEF = 403702,
  parameter logic signed [W-1:0] U_MAX = 26214400
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] y_meas,
  input  logic signed [W-1:0] r_set,
  output logic signed [W-1:0] u_out,
  output logic                done
);
  localparam int PW = 2 * W;
  localparam int KW = $clog2(HOR);
  localparam longint HALF = 64'd1 << (FRAC - 1);

  typedef enum logic [2:0] {S_IDLE, S_AX, S_BU, S_PA, S_PH, S_FIN} st_t;
  st_t st;

  logic signed [W-1:0] u_q, x_q, y_q, r_q, xf, xn, bu, nd, acc;
  logic signed [W-1:0] opa, opb, rnd, err, xb;
  logic signed [PW-1:0] prod, prod_r;
  logic signed [W:0] usum;
  logic signed [W-1:0] u_new;
  logic [KW-1:0] k;

  function automatic logic signed [W-1:0] gain(input logic [KW-1:0] i);
    case (i)
      0: gain = 656;
      1: gain = 1273;
      2: gain = 1853;
      3: gain = 2398;
      4: gain = 2911;
      5: gain = 3393;
      6: gain = 3845;
      7: gain = 4271;
      8: gain = 4671;
      9: gain = 5047;
      default: gain = '0;
    endcase
  endfunction

  always_comb begin
    case (st)
      S_AX:    begin opa = A_COEF;  opb = x_q; end
      S_BU:    begin opa = B_COEF;  opb = u_q; end
      S_PA:    begin opa = A_COEF;  opb = xf;  end
      S_PH:    begin opa = gain(k); opb = err; end
      default: begin opa = '0;      opb = '0;  end
    endcase
  end

  assign err    = r_q - xf - nd;
  assign prod   = PW'(opa) * PW'(opb);
  assign prod_r = prod + PW'(HALF);
  assign rnd    = prod_r[FRAC+W-1:FRAC];
  assign xb     = xf + rnd;
  assign usum   = {u_q[W-1], u_q} + {acc[W-1], acc};
  assign u_new  = usum[W] ? '0 : (usum > (W+1)'(U_MAX)) ? U_MAX : usum[W-1:0];
  assign u_out  = u_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; done <= 1'b0; k <= '0;
      u_q <= '0; x_q <= '0; y_q <= '0; r_q <= '0;
      xf <= '0; xn <= '0; bu <= '0; nd <= '0; acc <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          y_q <= y_meas; r_q <= r_set; st <= S_AX;
        end
        S_AX: begin xf <= rnd; st <= S_BU; end
        S_BU: begin
          bu <= rnd; xn <= xb; xf <= xb; nd <= y_q - xb;
          acc <= '0; k <= '0; st <= S_PA;
        end
        S_PA: begin xf <= rnd + bu; st <= S_PH; end
        S_PH: begin
          acc <= acc + rnd;
          if (k == KW'(HOR - 1)) st <= S_FIN;
          else begin k <= k + 1'b1; st <= S_PA; end
        end
        S_FIN: begin
          u_q <= u_new; x_q <= xn; done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_u_range_r6: assert property (@(posedge clk) disable iff (rst)
    (u_q >= 0) && (u_q <= U_MAX)) else $error("u out of range");
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle");
  p_u_on_done_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(u_q) |-> done) else $error("u changed without done");
  p_fin_done_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN) |=> done) else $error("done missing");
  p_busy_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> (st != S_AX)) else $error("restart while busy");
  p_k_range_r5: assert property (@(posedge clk) disable iff (rst)
    k < KW'(HOR)) else $error("index out of range");
endmodule

// File: tb/spd_pred_ctrl_test.sv
module spd_pred_ctrl_test;
  localparam int CLK_PER = 10;
  localparam longint UMAX = 26214400;
  localparam longint ONE = 262144;

  logic clk = 0, rst = 1, start = 0;
  logic signed [31:0] y_meas = '0, r_set = '0;
  logic signed [31:0] u_out;
  logic done;

  int checks = 0, errors = 0;
  longint mx = 0, mu = 0;
  longint H [10] = '{656, 1273, 1853, 2398, 2911, 3393, 3845, 4271, 4671, 5047};

  spd_pred_ctrl uut (.clk(clk), .rst(rst), .start(start), .y_meas(y_meas),
                     .r_set(r_set), .u_out(u_out), .done(done));

  always #(CLK_PER/2) clk = ~clk;

  function automatic longint rnd(longint p);
    return (p + 131072) >>> 18;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input longint y, input longint r, output longint u);
    longint xn, bu, n, xf, acc, s;
    xn = rnd(246415 * mx) + rnd(403702 * mu);
    bu = rnd(403702 * mu);
    n = y - xn; xf = xn; acc = 0;
    for (int k = 0; k < 10; k++) begin
      xf = rnd(246415 * xf) + bu;
      acc += rnd(H[k] * (r - xf - n));
    end
    s = mu + acc;
    if (s < 0) s = 0;
    if (s > UMAX) s = UMAX;
    mx = xn; mu = s; u = s;
  endtask

  task automatic run_update(input longint y, input longint r, input string tag,
                            input bit poke = 0, output longint exp);
    int cyc;
    model_step(y, r, exp);
    @(negedge clk); y_meas = 32'(y); r_set = 32'(r); start = 1;
    @(negedge clk); start = 0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 5) begin
        start = 1; y_meas = 32'(y + 50 * ONE); r_set = 32'(r - 30 * ONE);
      end else if (poke && cyc == 6) start = 0;
    end
    chk(cyc == 23, {tag, " R7 latency"}, cyc, 23);
    chk(u_out == 32'(exp), {tag, " R5 R6 command"}, u_out, exp);
    @(negedge clk);
    chk(done == 0, {tag, " R7 single-cycle done"}, done, 0);
    chk(u_out == 32'(exp), {tag, " R7 command held"}, u_out, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(u_out == 0, "R1 reset command", u_out, 0);
    chk(done == 0, "R1 reset done", done, 0);
  endtask

  task automatic t_first;
    longint e;
    run_update(0, 10 * ONE, "first R3", 0, e);
    chk(e > 0 && e < 2 * ONE, "R2 first move magnitude", e, 0);
  endtask

  task automatic t_track;
    longint e;
    run_update(mx, 10 * ONE, "match R9", 0, e);
    run_update(mx + 2 * ONE, 10 * ONE, "offset R4", 0, e);
    run_update(mx - $rtoi(1.5 * ONE), 10 * ONE, "neg offset R4", 0, e);
    run_update(mx, 25 * ONE, "step R3", 0, e);
    run_update(mx + 7, 25 * ONE, "chain R9", 0, e);
  endtask

  task automatic t_sat;
    longint e;
    run_update(mx, 2000 * ONE, "clamp hi R6", 0, e);
    chk(e == UMAX && u_out == 32'(UMAX), "R6 upper limit", u_out, UMAX);
    run_update(mx, -2000 * ONE, "clamp lo R6", 0, e);
    chk(e == 0 && u_out == 0, "R6 lower limit", u_out, 0);
  endtask

  task automatic t_busy;
    longint e;
    run_update(mx + ONE, 12 * ONE, "busy start R8", 1, e);
    repeat (30) begin
      @(negedge clk);
      chk(done == 0, "R8 no second update", done, 0);
    end
  endtask

  task automatic t_reset_mid;
    longint e;
    @(negedge clk); y_meas = 32'(3 * ONE); r_set = 32'(40 * ONE); start = 1;
    @(negedge clk); start = 0;
    repeat (8) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    mx = 0; mu = 0;
    chk(u_out == 0, "R1 reset mid-run command", u_out, 0);
    repeat (30) begin
      @(negedge clk);
      chk(done == 0, "R1 aborted update silent", done, 0);
    end
    run_update(0, 10 * ONE, "after reset R1", 0, e);
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_first;
    t_track;
    t_sat;
    t_busy;
    t_reset_mid;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule